// File: doc/BRIEF.md
# Software-Triggered Configuration Crossing Bridge

This block moves a bundle of configuration settings from a fast register clock domain into a slow clock domain. The bundle holds a control field, a six-bit wakeup enable mask and a two-bit reset enable mask. The slow domain does not follow changes on the fast-side settings. It picks up a new copy only when software asks for one.

Software asks for a copy by writing 1 to a sync bit. That write takes a snapshot of the configuration in the fast domain, sets the sync bit, and flips a request toggle. The request toggle crosses into the slow domain through a flop synchronizer. The slow domain loads the snapshot into its copy and flips an acknowledge toggle, which crosses back the same way. When the acknowledge arrives, the sync bit clears itself. Software polls the bit and treats the slow-domain settings as current once the bit reads 0.

Top module: `cfgx_sync_bridge`

## Requirements
- R1: After reset the sync bit reads 0, and the slow-domain copy holds the reset defaults: control 5'b11000, wakeup mask 0, reset mask 0.
- R2: A change on the fast-side configuration inputs does not change the slow-domain copy unless a sync is requested.
- R3: A write strobe with write data 1 while the sync bit is 0 sets the sync bit, visible one fast cycle after the write.
- R4: A write strobe with write data 0 has no effect: the sync bit stays 0 and the slow copy is unchanged.
- R5: The slow copy takes the configuration value that was present in the fast cycle of the accepted write. It updates on the third slow rising edge after that write, with the default two-stage synchronizer.
- R6: A change on the configuration inputs after an accepted write does not affect the value that write delivers.
- R7: The sync bit clears on the third fast rising edge after the slow-domain update, and it stays 1 until then.
- R8: A write of 1 while the sync bit is 1 is ignored. The bit stays 1 until the pending sync completes, and no second transfer happens.
- R9: Syncs issued back to back, each started after the previous one has cleared, each deliver their own snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast register-domain clock |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| clk_slow | input | 1 | Slow consumer-domain clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| sync_wr | input | 1 | Write strobe for the sync bit |
| sync_wdata | input | 1 | Data written with the strobe |
| cfg_ctrl_in | input | CTRL_W | Control field, fast domain |
| cfg_wake_en_in | input | WAKE_W | Wakeup enable mask, fast domain |
| cfg_rst_en_in | input | RST_W | Reset enable mask, fast domain |
| sync_busy | output | 1 | Sync bit read value; 1 while a transfer is in flight |
| cfg_ctrl_slow | output | CTRL_W | Control field, slow domain copy |
| cfg_wake_en_slow | output | WAKE_W | Wakeup enable mask, slow domain copy |
| cfg_rst_en_slow | output | RST_W | Reset enable mask, slow domain copy |

## Verification
The sync bit rises one fast cycle after an accepted write. The slow copy changes on the third slow rising edge after that write. The sync bit falls on the third fast rising edge after the slow update. The bench reference model counts these edges separately in each clock domain. It compares the sync bit at every fast falling edge and the slow copy at every slow falling edge, so each result is sampled half a period after the edge that produces it. The two clocks are offset so that their rising edges never coincide, which keeps the edge counts unambiguous.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  // Fewest synchronizer stages accepted on either crossing
  localparam int unsigned CFGX_MIN_STAGES = 2;

  // Stage count actually built for a requested depth
  function automatic int unsigned cfgx_stages(input int unsigned req);
    return (req < CFGX_MIN_STAGES) ? CFGX_MIN_STAGES : req;
  endfunction
endpackage

// File: rtl/cfgx_bit_sync.sv
module cfgx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgx_fast_req.sv
module cfgx_fast_req #(
  parameter int unsigned W = 13,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         wdata,
  input  logic [W-1:0] cfg_in,
  input  logic         ack_sync,
  output logic         busy,
  output logic         req_tgl,
  output logic [W-1:0] shadow
);
  logic start, done;

  // Starting is allowed only when idle; a write while busy is dropped
  assign start = wr & wdata & ~busy;
  assign done  = busy & (ack_sync == req_tgl);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      req_tgl <= 1'b0;
      shadow  <= RST_VAL;
    end else if (start) begin
      busy    <= 1'b1;
      req_tgl <= ~req_tgl;
      shadow  <= cfg_in;
    end else if (done) begin
      busy    <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgx_slow_cap.sv
module cfgx_slow_cap #(
  parameter int unsigned W = 13,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_sync,
  input  logic [W-1:0] shadow_in,
  output logic         ack_tgl,
  output logic [W-1:0] cfg_out
);
  logic cap;

  // A request is pending while its toggle differs from the returned one
  assign cap = req_sync ^ ack_tgl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_tgl <= 1'b0;
      cfg_out <= RST_VAL;
    end else if (cap) begin
      ack_tgl <= req_sync;
      cfg_out <= shadow_in;
    end
  end
endmodule

// File: rtl/cfgx_sync_bridge.sv
module cfgx_sync_bridge
  import cfgx_pkg::*;
#(
  parameter int unsigned CTRL_W = 5,
  parameter int unsigned WAKE_W = 6,
  parameter int unsigned RST_W  = 2,
  parameter logic [CTRL_W-1:0] CTRL_RST = 5'b11000,
  parameter logic [WAKE_W-1:0] WAKE_RST = '0,
  parameter logic [RST_W-1:0]  RSTEN_RST = '0,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              rst_fast,
  input  logic              clk_slow,
  input  logic              rst_slow,
  input  logic              sync_wr,
  input  logic              sync_wdata,
  input  logic [CTRL_W-1:0] cfg_ctrl_in,
  input  logic [WAKE_W-1:0] cfg_wake_en_in,
  input  logic [RST_W-1:0]  cfg_rst_en_in,
  output logic              sync_busy,
  output logic [CTRL_W-1:0] cfg_ctrl_slow,
  output logic [WAKE_W-1:0] cfg_wake_en_slow,
  output logic [RST_W-1:0]  cfg_rst_en_slow
);
  localparam int unsigned TOT_W  = CTRL_W + WAKE_W + RST_W;
  localparam int unsigned NSTAGE = cfgx_stages(STAGES);
  localparam logic [TOT_W-1:0] BUS_RST = {CTRL_RST, WAKE_RST, RSTEN_RST};

  logic             req_tgl, req_at_slow;
  logic             ack_tgl, ack_at_fast;
  logic [TOT_W-1:0] shadow_bus, slow_bus;

  cfgx_fast_req #(.W(TOT_W), .RST_VAL(BUS_RST)) u_fast (
    .clk      (clk_fast),
    .rst      (rst_fast),
    .wr       (sync_wr),
    .wdata    (sync_wdata),
    .cfg_in   ({cfg_ctrl_in, cfg_wake_en_in, cfg_rst_en_in}),
    .ack_sync (ack_at_fast),
    .busy     (sync_busy),
    .req_tgl  (req_tgl),
    .shadow   (shadow_bus)
  );

  cfgx_bit_sync #(.STAGES(NSTAGE)) u_req_sync (
    .clk (clk_slow),
    .rst (rst_slow),
    .d   (req_tgl),
    .q   (req_at_slow)
  );

  cfgx_slow_cap #(.W(TOT_W), .RST_VAL(BUS_RST)) u_slow (
    .clk       (clk_slow),
    .rst       (rst_slow),
    .req_sync  (req_at_slow),
    .shadow_in (shadow_bus),
    .ack_tgl   (ack_tgl),
    .cfg_out   (slow_bus)
  );

  cfgx_bit_sync #(.STAGES(NSTAGE)) u_ack_sync (
    .clk (clk_fast),
    .rst (rst_fast),
    .d   (ack_tgl),
    .q   (ack_at_fast)
  );

  assign {cfg_ctrl_slow, cfg_wake_en_slow, cfg_rst_en_slow} = slow_bus;
endmodule

// File: rtl/cfgx_sync_checker.sv
module cfgx_sync_checker #(
  parameter int unsigned TOT_W = 13
) (
  input logic             clk_fast,
  input logic             rst_fast,
  input logic             clk_slow,
  input logic             rst_slow,
  input logic             sync_wr,
  input logic             sync_wdata,
  input logic             sync_busy,
  input logic             req_tgl,
  input logic             ack_at_fast,
  input logic             ack_tgl,
  input logic [TOT_W-1:0] shadow_bus,
  input logic [TOT_W-1:0] slow_bus
);
  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk_fast) disable iff (rst_fast)
    $past(rst_fast) |-> !sync_busy);

  // R3
  a_r3_write_sets_busy: assert property (@(posedge clk_fast) disable iff (rst_fast)
    (sync_wr && sync_wdata && !sync_busy) |=> sync_busy);

  // R4, R8
  a_r8_busy_rises_on_write: assert property (@(posedge clk_fast) disable iff (rst_fast)
    $rose(sync_busy) |-> $past(sync_wr && sync_wdata));

  // R7
  a_r7_hold_until_ack: assert property (@(posedge clk_fast) disable iff (rst_fast)
    (sync_busy && (ack_at_fast != req_tgl)) |=> sync_busy);

  // R6
  a_r6_snapshot_frozen: assert property (@(posedge clk_fast) disable iff (rst_fast)
    (sync_busy && $past(sync_busy)) |-> $stable(shadow_bus));

  // R2
  a_r2_copy_moves_with_ack: assert property (@(posedge clk_slow) disable iff (rst_slow)
    !$stable(slow_bus) |-> (ack_tgl != $past(ack_tgl)));

  // R5
  a_r5_copy_matches_snapshot: assert property (@(posedge clk_slow) disable iff (rst_slow)
    (ack_tgl != $past(ack_tgl)) |-> (slow_bus == $past(shadow_bus)));
endmodule

bind cfgx_sync_bridge cfgx_sync_checker #(.TOT_W(TOT_W)) u_chk (
  .clk_fast    (clk_fast),
  .rst_fast    (rst_fast),
  .clk_slow    (clk_slow),
  .rst_slow    (rst_slow),
  .sync_wr     (sync_wr),
  .sync_wdata  (sync_wdata),
  .sync_busy   (sync_busy),
  .req_tgl     (req_tgl),
  .ack_at_fast (ack_at_fast),
  .ack_tgl     (ack_tgl),
  .shadow_bus  (shadow_bus),
  .slow_bus    (slow_bus)
);

// File: tb/test_cfgx_sync_bridge.sv
`timescale 1ns/1ps
module test_cfgx_sync_bridge;
  localparam logic [4:0] D_CTRL = 5'b11000;
  localparam logic [5:0] D_WAKE = 6'h00;
  localparam logic [1:0] D_RST  = 2'b00;

  logic clk_fast = 1'b0, clk_slow = 1'b0;
  logic rst_fast = 1'b1, rst_slow = 1'b1;
  logic sync_wr = 1'b0, sync_wdata = 1'b0;
  logic [4:0] c_in = D_CTRL;
  logic [5:0] w_in = D_WAKE;
  logic [1:0] r_in = D_RST;
  logic       sync_busy;
  logic [4:0] c_out;
  logic [5:0] w_out;
  logic [1:0] r_out;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit seen_f = 0, seen_s = 0, done = 0;

  always #2.5 clk_fast = ~clk_fast;
  initial begin #1; forever #20 clk_slow = ~clk_slow; end

  cfgx_sync_bridge i_cfgx_sync_bridge (
    .clk_fast(clk_fast), .rst_fast(rst_fast), .clk_slow(clk_slow), .rst_slow(rst_slow),
    .sync_wr(sync_wr), .sync_wdata(sync_wdata),
    .cfg_ctrl_in(c_in), .cfg_wake_en_in(w_in), .cfg_rst_en_in(r_in),
    .sync_busy(sync_busy),
    .cfg_ctrl_slow(c_out), .cfg_wake_en_slow(w_out), .cfg_rst_en_slow(r_out)
  );

  // Reference model: edge counting per domain
  logic        exp_busy = 1'b0;
  logic [12:0] exp_cfg = {D_CTRL, D_WAKE, D_RST};
  logic [12:0] snap = '0;
  int start_num = 0, start_seen = 0, slow_cnt = 0;
  int cap_num = 0, cap_seen = 0, fast_cnt = 0;

  always @(posedge clk_fast) begin
    seen_f = 1;
    if (rst_fast) begin
      exp_busy = 0; fast_cnt = 0; cap_seen = cap_num;
    end else if (cap_num != cap_seen) begin
      fast_cnt++;
      if (fast_cnt == 3) begin exp_busy = 0; cap_seen = cap_num; fast_cnt = 0; end
    end else if (!exp_busy && sync_wr && sync_wdata) begin
      exp_busy = 1; snap = {c_in, w_in, r_in}; start_num++;
    end
  end

  always @(posedge clk_slow) begin
    seen_s = 1;
    if (rst_slow) begin
      exp_cfg = {D_CTRL, D_WAKE, D_RST}; slow_cnt = 0; start_seen = start_num;
    end else if (start_num != start_seen) begin
      slow_cnt++;
      if (slow_cnt == 3) begin
        exp_cfg = snap; start_seen = start_num; slow_cnt = 0; cap_num++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_fast) if (seen_f && !rst_fast && !done)
    check(tag, {31'd0, sync_busy}, {31'd0, exp_busy});
  always @(negedge clk_slow) if (seen_s && !rst_slow && !done)
    check(tag, {19'd0, c_out, w_out, r_out}, {19'd0, exp_cfg});

  task automatic set_cfg(input logic [4:0] c, input logic [5:0] w, input logic [1:0] r);
    @(negedge clk_fast); c_in = c; w_in = w; r_in = r;
  endtask

  task automatic pulse(input logic v);
    @(negedge clk_fast); sync_wr = 1; sync_wdata = v;
    @(negedge clk_fast); sync_wr = 0; sync_wdata = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (sync_busy && n < 400) begin @(negedge clk_fast); n++; end
    check(req, {31'd0, sync_busy}, 32'd0);
  endtask

  task automatic out_is(input string req, input logic [12:0] v);
    @(negedge clk_slow);
    check(req, {19'd0, c_out, w_out, r_out}, {19'd0, v});
  endtask

  initial begin
    repeat (4) @(negedge clk_slow);
    rst_slow = 0;
    @(negedge clk_fast); rst_fast = 0;
    repeat (2) @(negedge clk_fast);
    // R1 reset state
    check("R1", {31'd0, sync_busy}, 32'd0);
    out_is("R1", {D_CTRL, D_WAKE, D_RST});
    // R2 input change without sync
    tag = "R2";
    set_cfg(5'b00101, 6'h2A, 2'b01);
    repeat (8) @(negedge clk_slow);
    out_is("R2", {D_CTRL, D_WAKE, D_RST});
    // R4 write of 0
    tag = "R4";
    pulse(1'b0);
    check("R4", {31'd0, sync_busy}, 32'd0);
    repeat (6) @(negedge clk_slow);
    out_is("R4", {D_CTRL, D_WAKE, D_RST});
    // R3 accepted write, R6 inputs change while pending
    tag = "R3";
    pulse(1'b1);
    check("R3", {31'd0, sync_busy}, 32'd1);
    tag = "R6";
    set_cfg(5'b10010, 6'h15, 2'b10);
    tag = "R7";
    wait_idle("R7");
    out_is("R5", {5'b00101, 6'h2A, 2'b01});
    out_is("R6", {5'b00101, 6'h2A, 2'b01});
    // R8 write while busy
    tag = "R8";
    set_cfg(5'b01111, 6'h3F, 2'b11);
    pulse(1'b1);
    set_cfg(5'b00001, 6'h01, 2'b00);
    repeat (3) @(negedge clk_fast);
    pulse(1'b1);
    check("R8", {31'd0, sync_busy}, 32'd1);
    wait_idle("R8");
    repeat (8) @(negedge clk_slow);
    out_is("R8", {5'b01111, 6'h3F, 2'b11});
    check("R8", {31'd0, sync_busy}, 32'd0);
    // R9 back-to-back syncs
    tag = "R9";
    set_cfg(5'b11100, 6'h0C, 2'b10);
    pulse(1'b1);
    wait_idle("R9");
    set_cfg(5'b00011, 6'h33, 2'b01);
    pulse(1'b1);
    wait_idle("R9");
    out_is("R9", {5'b00011, 6'h33, 2'b01});
    repeat (4) @(negedge clk_slow);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule